// File: doc/BRIEF.md
# Four-Lane Sample Packer with Fill-Threshold DMA Request

This block takes in samples from two dual-output A/D converters. Every capture strobe delivers four 8-bit samples at once, and the block writes one of them into each of four lane FIFOs. The four lanes always move together, so a single shared occupancy count covers all of them. Each FIFO holds 80 entries.

A host DMA engine drains the block with bursts of back-to-back bus reads. Each read returns a 32-bit word made from the head byte of every lane and pops that entry from all four lanes. The block raises a level request once the backlog reaches the threshold of 64 entries. The host reads slightly faster than samples arrive, so the backlog drains slowly while capture goes on during the burst.

A single enable input controls acquisition. Two sticky status outputs report lost samples (overflow) and reads of an empty store (underflow).

Top module: `quad_lane_packer`

## Requirements
- R1: While `acq_en` is high, a `smp_valid` strobe stores `smp_data[8i+7:8i]` into lane i, for i = 0..3.
- R2: `rd_data` presents the oldest stored entry packed as lane 0 in bits 7:0, lane 1 in bits 15:8, lane 2 in bits 23:16 and lane 3 in bits 31:24. A cycle with `rd_strobe` high pops that entry from all four lanes at the clock edge, and entries come out in arrival order.
- R3: The store holds 80 entries. A strobe that arrives while all 80 are occupied, with no read in the same cycle, is dropped, leaves the stored contents unchanged, and sets `ovf_flag`.
- R4: `ovf_flag` stays high for as long as `acq_en` stays high. It clears only at a clock edge where `acq_en` is low.
- R5: `dma_req` is high while `acq_en` is high and at least 64 entries are stored. It is low whenever fewer are stored, including right after a read takes the count from 64 to 63.
- R6: A read while the store is empty returns zero on `rd_data` and changes no stored state. It sets the sticky `udf_flag`, which clears under the same rule as `ovf_flag`.
- R7: A capture and a read in the same cycle both take effect. When the store is full, the read frees the slot the new sample takes. When the store is empty, the read counts as an underflow and the sample is still stored.
- R8: While `acq_en` is low, `dma_req` and `rd_data` are zero and strobes and reads are ignored. At the next clock edge all lanes are flushed and both flags are cleared.
- R9: Reset is synchronous and active high. It empties the store and drives `dma_req`, `ovf_flag`, `udf_flag` and `rd_data` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_en | input | 1 | Acquisition enable; low flushes the store |
| smp_valid | input | 1 | Capture strobe for one set of four samples |
| smp_data | input | 32 | Four samples, lane i in bits 8i+7:8i |
| rd_strobe | input | 1 | Host read; pops one entry from all lanes |
| rd_data | output | 32 | Packed head entry, or zero when empty or disabled |
| dma_req | output | 1 | Level request, high while fill is at or above 64 |
| ovf_flag | output | 1 | Sticky flag for a dropped sample |
| udf_flag | output | 1 | Sticky flag for a read of an empty store |

## Verification
The bench targets the edges of the occupancy count.

- **Threshold crossing (63 to 64 and back).** A request built on "greater than" or on a registered compare would show up one entry late or linger one read too long.
- **Strobe at full occupancy.** A design with a wrong full test would overwrite the oldest entry, or store the sample and corrupt the order the drain returns.
- **Simultaneous capture and read at both extremes.** At full, a design that drops the sample loses a word. At empty, a design that pops anyway wraps the count and returns garbage on later reads.
- **Disabling enable.** After disabling, the bench checks that stale data, flags and the request are gone, and that traffic sent while disabled left nothing behind.

// File: rtl/qlp_pkg.sv
package qlp_pkg;

    localparam int QLP_LANES  = 4;
    localparam int QLP_SMP_W  = 8;
    localparam int QLP_DEPTH  = 80;
    localparam int QLP_THRESH = 64;

    // Per-cycle operation decode shared by the occupancy logic.
    typedef struct packed {
        logic push;    // sample accepted into every lane
        logic pop;     // head entry removed from every lane
        logic drop;    // sample refused because the store is full
        logic starve;  // read issued against an empty store
    } qlp_op_t;

    // Circular pointer advance for a store of arbitrary depth.
    function automatic int qlp_wrap_inc(input int ptr, input int depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/qlp_lane_store.sv
module qlp_lane_store #(
    parameter int SMP_W = 8,
    parameter int DEPTH = 80,
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [SMP_W-1:0] wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [SMP_W-1:0] rdata
);

    logic [SMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/qlp_fill_ctrl.sv
module qlp_fill_ctrl
    import qlp_pkg::*;
#(
    parameter int DEPTH  = 80,
    parameter int THRESH = 64,
    parameter int PTR_W  = 7,
    parameter int CNT_W  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             valid,
    input  logic             rd,
    output logic             push_en,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [CNT_W-1:0] fill,
    output logic             ovf,
    output logic             udf,
    output logic             req
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] REQ_CNT  = CNT_W'(THRESH);

    qlp_op_t op;
    logic    is_empty;
    logic    is_full;

    assign is_empty = (fill == '0);
    assign is_full  = (fill == FULL_CNT);

    always_comb begin
        op        = '0;
        op.pop    = en && rd && !is_empty;
        op.starve = en && rd && is_empty;
        op.push   = en && valid && (!is_full || op.pop);
        op.drop   = en && valid && !op.push;
    end

    assign push_en = op.push;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
            ovf  <= 1'b0;
            udf  <= 1'b0;
        end else begin
            if (op.push) begin
                wptr <= PTR_W'(qlp_wrap_inc(int'(wptr), DEPTH));
            end
            if (op.pop) begin
                rptr <= PTR_W'(qlp_wrap_inc(int'(rptr), DEPTH));
            end
            fill <= fill + CNT_W'(op.push) - CNT_W'(op.pop);
            ovf  <= ovf | op.drop;
            udf  <= udf | op.starve;
        end
    end

    assign req = en && (fill >= REQ_CNT);

endmodule

// File: rtl/quad_lane_packer.sv
module quad_lane_packer
    import qlp_pkg::*;
#(
    parameter  int LANES  = QLP_LANES,
    parameter  int SMP_W  = QLP_SMP_W,
    parameter  int DEPTH  = QLP_DEPTH,
    parameter  int THRESH = QLP_THRESH,
    localparam int WORD_W = LANES * SMP_W,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acq_en,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_data,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    output logic              dma_req,
    output logic              ovf_flag,
    output logic              udf_flag
);

    logic             push_en;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic [CNT_W-1:0] fill_cnt;
    logic [WORD_W-1:0] head_word;

    qlp_fill_ctrl #(
        .DEPTH  (DEPTH),
        .THRESH (THRESH),
        .PTR_W  (PTR_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en      (acq_en),
        .valid   (smp_valid),
        .rd      (rd_strobe),
        .push_en (push_en),
        .wptr    (wptr),
        .rptr    (rptr),
        .fill    (fill_cnt),
        .ovf     (ovf_flag),
        .udf     (udf_flag),
        .req     (dma_req)
    );

    // One storage lane per sample slot; all lanes share the pointers.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qlp_lane_store #(
            .SMP_W (SMP_W),
            .DEPTH (DEPTH),
            .PTR_W (PTR_W)
        ) u_store (
            .clk   (clk),
            .we    (push_en),
            .waddr (wptr),
            .wdata (smp_data[g*SMP_W +: SMP_W]),
            .raddr (rptr),
            .rdata (head_word[g*SMP_W +: SMP_W])
        );
    end

    assign rd_data = (acq_en && fill_cnt != '0) ? head_word : '0;

endmodule

// File: rtl/quad_lane_packer_chk.sv
module quad_lane_packer_chk #(
    parameter int DEPTH  = 80,
    parameter int THRESH = 64,
    parameter int CNT_W  = 7,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              acq_en,
    input logic              smp_valid,
    input logic              rd_strobe,
    input logic [WORD_W-1:0] rd_data,
    input logic              dma_req,
    input logic              ovf_flag,
    input logic              udf_flag,
    input logic [CNT_W-1:0]  fill
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] REQ_CNT  = CNT_W'(THRESH);

    AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL_CNT); // R3

    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        acq_en && smp_valid && !rd_strobe && fill == FULL_CNT |=> ovf_flag && fill == FULL_CNT); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(acq_en) && $past(ovf_flag) |-> ovf_flag); // R4

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(acq_en) && $past(udf_flag) |-> udf_flag); // R6

    AST_REQ_RISE_AT_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req) |-> fill == REQ_CNT); // R5

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        acq_en && rd_strobe && fill == '0 |-> rd_data == '0); // R6

    AST_EMPTY_READ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        acq_en && rd_strobe && fill == '0 |=> udf_flag); // R6

    AST_BOTH_KEEP_FILL: assert property (@(posedge clk) disable iff (rst)
        acq_en && smp_valid && rd_strobe && fill != '0 |=> $stable(fill)); // R7

    AST_FLUSH_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !$past(acq_en) |-> fill == '0 && !ovf_flag && !udf_flag); // R8

endmodule

bind quad_lane_packer quad_lane_packer_chk #(
    .DEPTH  (DEPTH),
    .THRESH (THRESH),
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acq_en    (acq_en),
    .smp_valid (smp_valid),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .dma_req   (dma_req),
    .ovf_flag  (ovf_flag),
    .udf_flag  (udf_flag),
    .fill      (fill_cnt)
);

// File: tb/tb_quad_lane_packer.sv
module tb_quad_lane_packer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acq_en = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        rd_strobe = 1'b0;
    logic [31:0] rd_data;
    logic        dma_req;
    logic        ovf_flag;
    logic        udf_flag;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    quad_lane_packer dut (
        .clk       (clk),
        .rst       (rst),
        .acq_en    (acq_en),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data),
        .dma_req   (dma_req),
        .ovf_flag  (ovf_flag),
        .udf_flag  (udf_flag)
    );

    function automatic logic [31:0] pat(input int k);
        logic [7:0] b = 8'(k);
        return {b ^ 8'hC3, b + 8'h40, b * 8'd3, b};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] d);
        smp_valid = 1'b1;
        smp_data  = d;
        tick();
        smp_valid = 1'b0;
    endtask

    task automatic pop_expect(input logic [31:0] exp, input string req);
        chk(rd_data == exp, req, rd_data, exp);
        rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
    endtask

    task automatic t_reset();
        chk(dma_req == 1'b0, "R9 req", 32'(dma_req), 0);
        chk(ovf_flag == 1'b0, "R9 ovf", 32'(ovf_flag), 0);
        chk(udf_flag == 1'b0, "R9 udf", 32'(udf_flag), 0);
        chk(rd_data == '0, "R9 data", rd_data, 0);
    endtask

    task automatic t_threshold();
        acq_en = 1'b1;
        tick();
        for (int k = 0; k < 63; k++) push(pat(k));
        chk(dma_req == 1'b0, "R5 below", 32'(dma_req), 0);
        push(pat(63));
        chk(dma_req == 1'b1, "R5 at 64", 32'(dma_req), 1);
        for (int l = 0; l < 4; l++)
            chk(rd_data[l*8 +: 8] == pat(0)[l*8 +: 8], "R1 lane", 32'(rd_data[l*8 +: 8]), 32'(pat(0)[l*8 +: 8]));
        pop_expect(pat(0), "R2 head");
        chk(dma_req == 1'b0, "R5 drop at 63", 32'(dma_req), 0);
        for (int k = 1; k < 64; k++) pop_expect(pat(k), "R2 order");
        chk(ovf_flag == 1'b0, "R3 no ovf", 32'(ovf_flag), 0);
        chk(rd_data == '0, "R6 empty data", rd_data, 0);
        rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
        chk(udf_flag == 1'b1, "R6 udf set", 32'(udf_flag), 1);
        chk(rd_data == '0, "R6 still empty", rd_data, 0);
        push(pat(5));
        chk(rd_data == pat(5), "R6 no phantom pop", rd_data, pat(5));
        pop_expect(pat(5), "R6 drain");
        chk(udf_flag == 1'b1, "R6 sticky", 32'(udf_flag), 1);
        acq_en = 1'b0;
        tick();
        chk(udf_flag == 1'b0, "R8 udf clear", 32'(udf_flag), 0);
    endtask

    task automatic t_overflow();
        acq_en = 1'b1;
        tick();
        for (int k = 0; k < 80; k++) push(pat(k));
        chk(ovf_flag == 1'b0, "R3 full no ovf", 32'(ovf_flag), 0);
        push(32'hDEADBEEF);
        chk(ovf_flag == 1'b1, "R3 ovf set", 32'(ovf_flag), 1);
        chk(rd_data == pat(0), "R3 head kept", rd_data, pat(0));
        smp_valid = 1'b1;
        smp_data  = 32'hA5A55A5A;
        rd_strobe = 1'b1;
        tick();
        smp_valid = 1'b0;
        rd_strobe = 1'b0;
        for (int k = 1; k < 80; k++) pop_expect(pat(k), "R3 order");
        pop_expect(32'hA5A55A5A, "R7 full both");
        chk(rd_data == '0, "R7 drained", rd_data, 0);
        chk(ovf_flag == 1'b1, "R4 sticky", 32'(ovf_flag), 1);
        acq_en = 1'b0;
        tick();
        chk(ovf_flag == 1'b0, "R4 clear", 32'(ovf_flag), 0);
    endtask

    task automatic t_disable();
        acq_en = 1'b1;
        tick();
        for (int k = 0; k < 70; k++) push(pat(k + 7));
        chk(dma_req == 1'b1, "R5 high", 32'(dma_req), 1);
        acq_en = 1'b0;
        #1;
        chk(dma_req == 1'b0, "R8 req drop", 32'(dma_req), 0);
        chk(rd_data == '0, "R8 data gated", rd_data, 0);
        smp_valid = 1'b1;
        smp_data  = 32'h11223344;
        rd_strobe = 1'b1;
        tick();
        tick();
        smp_valid = 1'b0;
        rd_strobe = 1'b0;
        chk(udf_flag == 1'b0, "R8 read ignored", 32'(udf_flag), 0);
        acq_en = 1'b1;
        #1;
        chk(rd_data == '0, "R8 flushed", rd_data, 0);
        chk(dma_req == 1'b0, "R8 req flushed", 32'(dma_req), 0);
        tick();
        push(pat(9));
        chk(rd_data == pat(9), "R8 fresh start", rd_data, pat(9));
        pop_expect(pat(9), "R8 drain");
        acq_en = 1'b0;
        tick();
    endtask

    task automatic t_simul_empty();
        acq_en = 1'b1;
        tick();
        chk(rd_data == '0, "R7 empty", rd_data, 0);
        smp_valid = 1'b1;
        smp_data  = pat(20);
        rd_strobe = 1'b1;
        tick();
        smp_valid = 1'b0;
        rd_strobe = 1'b0;
        chk(udf_flag == 1'b1, "R7 udf", 32'(udf_flag), 1);
        chk(rd_data == pat(20), "R7 stored", rd_data, pat(20));
        pop_expect(pat(20), "R7 drain");
        acq_en = 1'b0;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        t_reset();
        rst = 1'b0;
        tick();
        t_reset();
        t_threshold();
        t_overflow();
        t_disable();
        t_simul_empty();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule